// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Streamer

This block is the read side of a serial configuration memory. It sends a stored bitstream to a programmable logic device one bit per clock. A bit address counter walks a fixed bit array from index 0 upward. The bit at the current address appears on `data_o`, and `data_oe` marks when that driver is active. The board-level tri-state bus is formed outside the block from this pair.

When the edge that consumes the final bit arrives, the block releases its driver and pulls `cas_n` low. Wiring that output to the `ce_n` input of a second instance lets the second instance continue the stream on the next clock. Several instances chained this way behave as one longer memory.

A reset/output-enable input clears the address. Its active level is chosen by a strap input. A high `ce_n` puts the block in standby: the driver is off and the address is frozen. A low `ser_en_n` selects programming mode, which only suppresses reading.

Top module: `cfg_bit_streamer`

## Requirements
- R1: While the block drives, `data_oe` is 1 and `data_o` equals `MEM_INIT[addr]`. The address starts at bit index 0 and rises by one at each rising clock edge.
- R2: After the rising edge on which the bit at index `LAST_ADDR` is driven, `cas_n` is 0 and `data_oe` is 0.
- R3: An active level on `rst_oe` at a rising edge clears the address to 0 and returns `cas_n` to 1. The next bit driven is index 0.
- R4: `rst_pol` = 1 makes `rst_oe` active when high, and `rst_pol` = 0 makes it active when low. While `rst_oe` is active, `data_oe` is 0.
- R5: If `rst_oe` stays inactive after the last bit, `cas_n` stays 0, `data_oe` stays 0 and the stream does not restart.
- R6: While `ce_n` is 1, `data_oe` is 0 whatever the level of `rst_oe`, and the address holds. When `ce_n` returns to 0, output resumes with the same bit.
- R7: While `ser_en_n` is 0, `data_oe` is 0 and the address holds.
- R8: When the `cas_n` of one instance drives the `ce_n` of the next, the combined output is the first pattern followed by the second. No cycle has both `data_oe` outputs at 1. Raising the upstream `ce_n` after it has finished does not stop the downstream instance.
- R9: `rst_n` low at a rising edge clears the address and sets `cas_n` to 1. This reset is synchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; the address advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; a high level means standby |
| rst_oe | input | 1 | Combined address reset and output enable; active level set by `rst_pol` |
| rst_pol | input | 1 | 1: `rst_oe` is active when high; 0: `rst_oe` is active when low |
| ser_en_n | input | 1 | Low selects programming mode, which blocks reads |
| data_o | output | 1 | Current bitstream bit; 0 when not driving |
| data_oe | output | 1 | Driver enable for `data_o` |
| cas_n | output | 1 | Cascade enable for the next device; low once the last bit has been sent |

## Verification
Two instances are chained and loaded with different patterns: 1,0,1,1 upstream and 0,1,0,0 downstream. Because the bit values differ, a wrong bit order, a missing or repeated bit at the hand-off, or a lane collision shows up in the merged stream.

That stream is broken up by a standby gap and a programming-mode gap at different positions. Each gap must resume on the same bit, which separates holding the address from skipping ahead. The upstream chip enable is raised after that instance has finished, to show that the downstream instance keeps going.

Directed steps follow. They check the finished state with output enable inactive, and a reset pulse on `rst_oe` under each polarity, where the stream must restart from the first device. They also check a mid-stream `rst_n` pulse and a standby while output enable is active.

// File: rtl/cfg_stream_pkg.sv
// Package: shared types and helpers for the configuration bitstream streamer.
// Assumes: nothing beyond IEEE 1800-2017.
package cfg_stream_pkg;

    // Why the driver is on or off; the order of the checks gives the priority.
    typedef enum logic [2:0] {
        DRV_RESET   = 3'd0,
        DRV_STANDBY = 3'd1,
        DRV_PROG    = 3'd2,
        DRV_SPENT   = 3'd3,
        DRV_ACTIVE  = 3'd4
    } drv_state_t;

    // Turn the raw reset/output-enable level into "reset asserted",
    // using the programmed polarity (1 = active when high).
    function automatic logic reset_asserted(input logic level, input logic active_high);
        return active_high ? level : ~level;
    endfunction

endpackage

// File: rtl/cfg_addr_counter.sv
// Module: bit address counter with an end-of-stream flag.
// What it does: steps the address once per enabled clock and stops after
//   the LAST_ADDR bit has been consumed, setting done_q.
// Assumes: clr and rst_n are sampled synchronously; clr wins over step_en.
module cfg_addr_counter #(
    parameter int AW        = 4,
    parameter int LAST_ADDR = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step_en,
    output logic [AW-1:0] addr_q,
    output logic          done_q
);

    localparam logic [AW-1:0] LAST_A = AW'(LAST_ADDR);
    localparam logic [AW-1:0] ONE_A  = AW'(1);

    logic at_last;

    // Flag the final bit position.
    always_comb begin
        at_last = (addr_q == LAST_A);
    end

    // Advance the address or mark the stream as consumed.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr_q <= '0;
            done_q <= 1'b0;
        end else if (step_en && !done_q) begin
            if (at_last) begin
                done_q <= 1'b1;
            end else begin
                addr_q <= addr_q + ONE_A;
            end
        end
    end

endmodule

// File: rtl/cfg_bit_array.sv
// Module: fixed bit array read by address.
// What it does: returns MEM_INIT[addr]; bit index 0 is sent first.
// Assumes: addr never exceeds DEPTH-1 (an out-of-range address reads 0).
module cfg_bit_array #(
    parameter int               DEPTH    = 16,
    parameter int               AW       = 4,
    parameter logic [DEPTH-1:0] MEM_INIT = '0
) (
    input  logic [AW-1:0] addr,
    output logic          bit_o
);

    logic [DEPTH-1:0] hit;

    // One decode line per stored bit, gated by the stored value.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        assign hit[g] = (addr == AW'(g)) & MEM_INIT[g];
    end

    // Merge the decoded cells into the read bit.
    always_comb begin
        bit_o = |hit;
    end

endmodule

// File: rtl/cfg_drive_ctrl.sv
// Module: output driver and cascade control.
// What it does: decides whether the data driver is on, and therefore
//   whether the counter may step; drives the cascade output from done.
// Assumes: reset has priority over standby, standby over programming mode,
//   and programming mode over the spent state.
module cfg_drive_ctrl
    import cfg_stream_pkg::*;
(
    input  logic rst_act,
    input  logic ce_n,
    input  logic ser_en_n,
    input  logic done,
    input  logic bit_i,
    output logic data_o,
    output logic data_oe,
    output logic cas_n,
    output logic step_en
);

    drv_state_t state;

    // Pick the driver state in priority order.
    always_comb begin
        if (rst_act) begin
            state = DRV_RESET;
        end else if (ce_n) begin
            state = DRV_STANDBY;
        end else if (!ser_en_n) begin
            state = DRV_PROG;
        end else if (done) begin
            state = DRV_SPENT;
        end else begin
            state = DRV_ACTIVE;
        end
    end

    // Drive the pins: data only when active, cascade from the done flag.
    always_comb begin
        data_oe = (state == DRV_ACTIVE);
        step_en = (state == DRV_ACTIVE);
        data_o  = (state == DRV_ACTIVE) ? bit_i : 1'b0;
        cas_n   = ~done;
    end

endmodule

// File: rtl/cfg_bit_streamer.sv
// Module: top of the cascadable configuration bitstream streamer.
// What it does: streams MEM_INIT bit 0 up to bit LAST_ADDR, one per clock,
//   then releases data and pulls cas_n low for the next device.
// Assumes: LAST_ADDR < DEPTH; MEM_INIT is fixed at build time.
module cfg_bit_streamer
    import cfg_stream_pkg::*;
#(
    parameter int               DEPTH     = 16,
    parameter int               LAST_ADDR = DEPTH - 1,
    parameter logic [DEPTH-1:0] MEM_INIT  = 16'hA5C3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic rst_oe,
    input  logic rst_pol,
    input  logic ser_en_n,
    output logic data_o,
    output logic data_oe,
    output logic cas_n
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          rst_act;
    logic          step_en;
    logic          done_q;
    logic          cur_bit;
    logic [AW-1:0] addr_q;

    // Resolve the programmable reset polarity.
    always_comb begin
        rst_act = reset_asserted(rst_oe, rst_pol);
    end

    cfg_addr_counter #(
        .AW        (AW),
        .LAST_ADDR (LAST_ADDR)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rst_act),
        .step_en (step_en),
        .addr_q  (addr_q),
        .done_q  (done_q)
    );

    cfg_bit_array #(
        .DEPTH    (DEPTH),
        .AW       (AW),
        .MEM_INIT (MEM_INIT)
    ) u_array (
        .addr  (addr_q),
        .bit_o (cur_bit)
    );

    cfg_drive_ctrl u_drive (
        .rst_act  (rst_act),
        .ce_n     (ce_n),
        .ser_en_n (ser_en_n),
        .done     (done_q),
        .bit_i    (cur_bit),
        .data_o   (data_o),
        .data_oe  (data_oe),
        .cas_n    (cas_n),
        .step_en  (step_en)
    );

endmodule

// File: rtl/cfg_bit_streamer_chk.sv
// Module: property checker for cfg_bit_streamer, attached by bind.
// Assumes: addr is the top's internal address register.
module cfg_bit_streamer_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          rst_oe,
    input logic          rst_pol,
    input logic          ser_en_n,
    input logic          data_oe,
    input logic          cas_n,
    input logic [AW-1:0] addr
);

    logic rst_on;

    // Reset level seen from the pins.
    always_comb begin
        rst_on = rst_pol ? rst_oe : ~rst_oe;
    end

    // R1
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |=> (addr == $past(addr) + 1'b1) || !cas_n);

    // R2
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !data_oe);

    // R3
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_on |=> (addr == '0) && cas_n);

    // R4
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_on |-> !data_oe);

    // R5
    spent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !rst_on) |=> !cas_n && $stable(addr));

    // R6
    standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !rst_on) |=> $stable(addr));

    // R6
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !data_oe);

    // R7
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en_n && !rst_on) |=> $stable(addr) && !$past(data_oe));

endmodule

bind cfg_bit_streamer cfg_bit_streamer_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .rst_oe   (rst_oe),
    .rst_pol  (rst_pol),
    .ser_en_n (ser_en_n),
    .data_oe  (data_oe),
    .cas_n    (cas_n),
    .addr     (addr_q)
);

// File: tb/test_cfg_bit_streamer.sv
// Bench: two chained streamers (A feeds B through cas_n -> ce_n).
// Pattern A bits from index 0: 1,0,1,1. Pattern B bits: 0,1,0,0.
module test_cfg_bit_streamer;

    logic clk = 1'b0;
    logic rst_n, ce_n_a, rst_oe, rst_pol, ser_en_n;
    logic d_a, oe_a, cas_a, d_b, oe_b, cas_b;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   reported = 1'b0;

    always #5 clk = ~clk;

    cfg_bit_streamer #(.DEPTH(4), .LAST_ADDR(3), .MEM_INIT(4'b1101)) i_cfg_bit_streamer (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n_a), .rst_oe(rst_oe), .rst_pol(rst_pol),
        .ser_en_n(ser_en_n), .data_o(d_a), .data_oe(oe_a), .cas_n(cas_a)
    );

    cfg_bit_streamer #(.DEPTH(4), .LAST_ADDR(3), .MEM_INIT(4'b0010)) i_cfg_bit_streamer_b (
        .clk(clk), .rst_n(rst_n), .ce_n(cas_a), .rst_oe(rst_oe), .rst_pol(rst_pol),
        .ser_en_n(ser_en_n), .data_o(d_b), .data_oe(oe_b), .cas_n(cas_b)
    );

    // Row: [5] ce_n_a, [4] ser_en_n, [3:2] drivers {oe_b,oe_a}, [1] bit, [0] cas_b
    localparam logic [5:0] VEC [12] = '{
        6'b0_1_01_1_1,  // A bit0
        6'b0_1_01_0_1,  // A bit1
        6'b1_1_00_0_1,  // standby gap (R6)
        6'b0_1_01_1_1,  // A bit2 resumes
        6'b0_0_00_0_1,  // programming gap (R7)
        6'b0_1_01_1_1,  // A bit3, last
        6'b0_1_10_0_1,  // hand-off, B bit0 (R2)
        6'b1_1_10_1_1,  // upstream ce high, B continues (R8)
        6'b0_1_10_0_1,  // B bit2
        6'b0_1_10_0_1,  // B bit3, last
        6'b0_1_00_0_0,  // both spent
        6'b0_1_00_0_0
    };

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
    endtask

    // Check drivers, the merged bit (when expected on) and no collision.
    task automatic chk_bus(input string req, input logic [1:0] drv, input logic b);
        chk({req, " drivers"}, {oe_b, oe_a}, drv);
        chk("R8 no collision", {1'b0, oe_a & oe_b}, 2'b00);
        if (drv != 2'b00) chk({req, " bit"}, {1'b0, oe_a ? d_a : d_b}, {1'b0, b});
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0; ce_n_a = 1'b1; ser_en_n = 1'b1; rst_oe = 1'b1; rst_pol = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R9 reset state
        chk("R9 cas_a after reset", {1'b0, cas_a}, 2'b01);
        chk("R9 cas_b after reset", {1'b0, cas_b}, 2'b01);
        chk("R9 drivers off in standby", {oe_b, oe_a}, 2'b00);

        // R1 R2 R6 R7 R8 main stream table
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            ce_n_a   = VEC[i][5];
            ser_en_n = VEC[i][4];
            #2;
            chk_bus("R1 R8 row", VEC[i][3:2], VEC[i][1]);
            chk("R2 R8 cas_b row", {1'b0, cas_b}, {1'b0, VEC[i][0]});
        end

        // R5: finished, rst_oe inactive: stays spent
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #2;
            chk("R5 cas_a held", {1'b0, cas_a}, 2'b00);
            chk("R5 cas_b held", {1'b0, cas_b}, 2'b00);
            chk("R5 no driver", {oe_b, oe_a}, 2'b00);
        end

        // R3 R4 active-low reset pulse restarts from device A
        @(negedge clk); rst_oe = 1'b0; #2;
        chk("R4 active-low quiet", {oe_b, oe_a}, 2'b00);
        @(negedge clk); rst_oe = 1'b1; #2;
        chk("R3 cas_a restored", {1'b0, cas_a}, 2'b01);
        chk("R3 cas_b restored", {1'b0, cas_b}, 2'b01);
        chk_bus("R3 R8 restart bit0", 2'b01, 1'b1);

        // R4 active-high polarity: rst_oe=1 is now reset
        @(negedge clk); rst_pol = 1'b1; #2;
        chk("R4 active-high quiet", {oe_b, oe_a}, 2'b00);
        @(negedge clk); rst_oe = 1'b0; #2;
        chk_bus("R4 active-high released bit0", 2'b01, 1'b1);
        @(negedge clk); #2;
        chk_bus("R1 bit1 under active-high", 2'b01, 1'b0);

        // R6 standby with output enable active
        @(negedge clk); ce_n_a = 1'b1; #2;
        chk("R6 standby ignores enable", {oe_b, oe_a}, 2'b00);
        @(negedge clk); ce_n_a = 1'b0; #2;
        chk_bus("R6 resumes bit2", 2'b01, 1'b1);

        // R9 mid-stream synchronous reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #2;
        chk("R9 cas_a after pulse", {1'b0, cas_a}, 2'b01);
        chk_bus("R9 restart bit0", 2'b01, 1'b1);

        report();
        $finish;
    end

endmodule